// File: doc/BRIEF.md
# Timer Overflow Square-Wave Divider

This block is an up-counting timer that restarts from a programmable start value, called the preload, each time it wraps past its top count. Every wrap raises a one-clock overflow strobe and flips a toggle flip-flop. The toggle gives a square wave whose frequency is the timer clock divided by 2×(256−N), where N is the preload. One output pin carries this square wave. The output bit of a port data latch acts as the only enable for that pin. When the latch bit is 0, the pin is forced low. When the latch bit is 1, the pin follows the toggle.

Software sets the frequency by writing the preload and starts or stops the timer with the run enable. Reloads take their value from a stored preload register. A write made while the timer runs therefore changes the period only from the next wrap onward. A write made while the timer is stopped also places the new value straight into the counter.

Top module: `tofd_top`

## Requirements
- R1: A synchronous reset clears the stored preload and the counter to 0, clears the toggle to 0 and drops the overflow strobe. After reset, `div_out` and `ovf_pulse` read 0.
- R2: While `run_en` is 1, the counter increments once per clock. The first overflow comes 256−N clocks after the run starts from count N, and each later overflow comes 256−N clocks after the one before.
- R3: `ovf_pulse` is registered. It is 1 for the one clock that follows each clock edge at which the count passes from 255 back to the preload. It is 1 at no other time.
- R4: The toggle inverts on every overflow, so the toggle period is 2×(256−N) clocks.
- R5: With `run_en` = 1 and `latch_bit` = 1, `div_out` equals the toggle value.
- R6: With `latch_bit` = 0, `div_out` is 0, whether or not the timer runs. The change takes effect in the same cycle, with no clock delay.
- R7: With `run_en` = 0, the counter and toggle hold their values and no overflow occurs. With `latch_bit` = 1, `div_out` keeps the last toggle value.
- R8: A preload write made while the timer runs does not disturb the current count. The new value is first used at the next reload.
- R9: A preload write made while the timer is stopped also loads the counter with the written value at that clock edge.
- R10: With N = 255, an overflow occurs on every clock. `ovf_pulse` stays 1 and the toggle inverts on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Timer run enable |
| pre_wr | input | 1 | Preload write strobe |
| pre_data | input | 8 | Preload write value N |
| latch_bit | input | 1 | Port data latch bit; acts as the output enable |
| div_out | output | 1 | Gated divider output |
| ovf_pulse | output | 1 | One-clock overflow strobe |

## Verification
The divider is driven from a table of preloads: 0, a mid value, a high value, 254 and 255. Each row runs with the latch bit set or cleared. Measuring the gap from the run start to the first strobe and to the second strobe separates a correct reload from an off-by-one count or a reload from zero. The value of `div_out` after each strobe separates toggling from gating. Directed runs cover three further cases. A preload write in mid-count shows whether the new value applies at once or only at the next wrap. A stop of several hundred clocks shows that the state is held. A write while stopped shows that the counter is loaded directly.

// File: rtl/tofd_pkg.sv
package tofd_pkg;
    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic run;
        logic wr;
        cnt_t wdata;
    } tmr_ctl_t;

    function automatic logic at_top(input cnt_t c);
        return c == CNT_MAX;
    endfunction
endpackage

// File: rtl/tofd_preload.sv
module tofd_preload
    import tofd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_ctl_t ctl,
    output cnt_t     pre_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (ctl.wr)
            pre_q <= ctl.wdata;
    end
endmodule

// File: rtl/tofd_counter.sv
module tofd_counter
    import tofd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_ctl_t ctl,
    input  cnt_t     pre_q,
    output cnt_t     cnt_q,
    output logic     wrap
);
    // wrap marks the edge at which the running count leaves its top value
    assign wrap = ctl.run && at_top(cnt_q);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ctl.run)
            cnt_q <= wrap ? pre_q : cnt_q + 1'b1;
        else if (ctl.wr)
            cnt_q <= ctl.wdata;
    end
endmodule

// File: rtl/tofd_divgate.sv
module tofd_divgate (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic latch_bit,
    output logic tog_q,
    output logic ovf_q,
    output logic pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (wrap)
                tog_q <= ~tog_q;
        end
    end

    assign pin = latch_bit & tog_q;
endmodule

// File: rtl/tofd_top.sv
module tofd_top
    import tofd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_data,
    input  logic             latch_bit,
    output logic             div_out,
    output logic             ovf_pulse
);
    tmr_ctl_t ctl;
    cnt_t     pre_q;
    cnt_t     cnt_q;
    logic     wrap;
    logic     tog_q;

    assign ctl = '{run: run_en, wr: pre_wr, wdata: pre_data};

    tofd_preload u_pre (.clk(clk), .rst(rst), .ctl(ctl), .pre_q(pre_q));

    tofd_counter u_cnt (.clk(clk), .rst(rst), .ctl(ctl), .pre_q(pre_q),
                        .cnt_q(cnt_q), .wrap(wrap));

    tofd_divgate u_div (.clk(clk), .rst(rst), .wrap(wrap), .latch_bit(latch_bit),
                        .tog_q(tog_q), .ovf_q(ovf_pulse), .pin(div_out));
endmodule

// File: rtl/tofd_checker.sv
module tofd_checker
    import tofd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic pre_wr,
    input logic latch_bit,
    input logic div_out,
    input logic ovf_pulse,
    input cnt_t cnt_q,
    input logic tog_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ovf_pulse && !div_out && cnt_q == '0));

    assert_strobe_from_top_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ($past(run_en) && $past(cnt_q) == CNT_MAX));

    assert_toggle_on_ovf_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (tog_q != $past(tog_q)));

    assert_pin_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (run_en && latch_bit) |-> (div_out == tog_q));

    assert_gate_low_R6: assert property (@(posedge clk) disable iff (rst)
        !latch_bit |-> !div_out);

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !pre_wr) |=> ($stable(cnt_q) && $stable(tog_q) && !ovf_pulse));
endmodule

bind tofd_top tofd_checker u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .pre_wr(pre_wr),
    .latch_bit(latch_bit), .div_out(div_out), .ovf_pulse(ovf_pulse),
    .cnt_q(cnt_q), .tog_q(tog_q)
);

// File: tb/tb_tofd_top.sv
module tb_tofd_top;
    logic       clk = 1'b0;
    logic       rst, run_en, pre_wr, latch_bit;
    logic [7:0] pre_data;
    logic       div_out, ovf_pulse;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    tofd_top dut (.clk(clk), .rst(rst), .run_en(run_en), .pre_wr(pre_wr),
                  .pre_data(pre_data), .latch_bit(latch_bit),
                  .div_out(div_out), .ovf_pulse(ovf_pulse));

    always #2 clk = ~clk;

    typedef struct packed {
        logic [7:0] n;
        logic       latch;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   1'b1}, '{8'd100, 1'b1}, '{8'd200, 1'b0},
        '{8'd254, 1'b1}, '{8'd255, 1'b1}, '{8'd37,  1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; run_en = 1'b0; pre_wr = 1'b0; pre_data = '0; latch_bit = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic write_pre(input logic [7:0] v);
        pre_wr = 1'b1; pre_data = v;
        tick();
        pre_wr = 1'b0;
    endtask

    // counts clock edges until ovf_pulse is seen, capped at lim
    task automatic wait_ovf(input int lim, output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while (!ovf_pulse && k < lim);
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k;
        do_reset();
        chk(div_out == 1'b0 && ovf_pulse == 1'b0, "R1 reset outputs", {div_out, ovf_pulse}, 0);

        // R2 R3 R4 R5 R6 R10: table walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            latch_bit = VECS[i].latch;
            write_pre(VECS[i].n);
            run_en = 1'b1;
            wait_ovf(600, k);
            chk(k == 256 - int'(VECS[i].n), "R2 first overflow gap", k, 256 - int'(VECS[i].n));
            chk(div_out == VECS[i].latch, "R5/R6 pin after first overflow", div_out, VECS[i].latch);
            if (VECS[i].n == 8'd255) begin
                tick();
                chk(ovf_pulse == 1'b1, "R10 strobe every clock", ovf_pulse, 1);
                chk(div_out == 1'b0, "R10 toggle every clock", div_out, 0);
            end else begin
                tick();
                chk(ovf_pulse == 1'b0, "R3 strobe one clock wide", ovf_pulse, 0);
                wait_ovf(600, k);
                chk(k + 1 == 256 - int'(VECS[i].n), "R2 R4 second overflow gap", k + 1, 256 - int'(VECS[i].n));
                chk(div_out == 1'b0, "R4 toggle back to 0", div_out, 0);
            end
        end

        // R6: latch 0 forces 0 while running with toggle high
        do_reset();
        write_pre(8'd250);
        run_en = 1'b1;
        wait_ovf(600, k);
        chk(div_out == 1'b1, "R5 pin high after overflow", div_out, 1);
        latch_bit = 1'b0;
        #1;
        chk(div_out == 1'b0, "R6 latch low forces 0", div_out, 0);
        latch_bit = 1'b1;
        #1;

        // R7: stop and hold
        run_en = 1'b0;
        begin
            int seen = 0;
            int drops = 0;
            for (int j = 0; j < 300; j++) begin
                tick();
                if (ovf_pulse) seen++;
                if (!div_out) drops++;
            end
            chk(seen == 0, "R7 no overflow while stopped", seen, 0);
            chk(drops == 0, "R7 pin holds last toggle", drops, 0);
        end
        // count held: resume, overflow should follow 250's schedule (6 edges from count 250 after wrap)
        run_en = 1'b1;
        wait_ovf(600, k);
        chk(k == 6, "R7 counter held across stop", k, 6);

        // R9: write while stopped loads counter
        do_reset();
        write_pre(8'd10);
        write_pre(8'd240);
        run_en = 1'b1;
        wait_ovf(600, k);
        chk(k == 16, "R9 stopped write loads counter", k, 16);

        // R8: write while running applies at next reload
        do_reset();
        run_en = 1'b1;
        for (int j = 0; j < 10; j++) tick();
        pre_wr = 1'b1; pre_data = 8'd200;
        tick();
        pre_wr = 1'b0;
        wait_ovf(600, k);
        chk(k + 11 == 256, "R8 current period unchanged", k + 11, 256);
        wait_ovf(600, k);
        chk(k == 56, "R8 new preload from next reload", k, 56);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule